// File: doc/BRIEF.md
# Synchronous Multiplexed Bus Target

This block is the device end of a host's synchronous external memory bus in which the address and the data share one 16-bit lane. Every event sits at a fixed whole-clock offset from the start of an access. While chip select and the address strobe are both low, the target takes the word address off the lane. After that, each clock in which write-enable is low stores one lane word into a 64-word register file. For a read access, the target waits a fixed number of clocks and then returns a burst of words, one per clock, on the same lane.

Clocks are numbered from the start of an access. Clock 1 is the first clock in which chip select is low. The address strobe is low in clocks 1 and 2. Output-enable or write-enable is low from clock 3. The lane is split into an input, an output and an output enable, so that a pad ring can build the bidirectional pin. The target enables its output only while it holds read data for a host that has both chip select and output-enable low. If chip select rises partway through a burst, the burst is abandoned.

Top module: `mux_bus_target`

## Requirements
- R1: After reset the lane output enable is low and all 64 register file entries read back as zero.
- R2: The word address is taken from the lane on every clock in which chip select and the address strobe are both low. Only its low 6 bits select a register file entry, so addresses that differ only above bit 5 reach the same word.
- R3: In each clock after the address phase in which chip select is low, the address strobe is high and write-enable is low, the lane word is stored at the current address. The address then advances by one, wrapping modulo 64 in the register file.
- R4: The first read word is loaded on the rising edge that ends clock 16, so it is on the lane for the whole of clock 17.
- R5: A read returns exactly 16 words, one per clock, from consecutive addresses. The output register changes only on a load.
- R6: The lane output enable is high only while a read burst is in progress and chip select and output-enable are both low.
- R7: If chip select goes high in the middle of a read or write burst, no further words are read or written, the lane is released, and the next access behaves normally.
- R8: A write with write-enable low for a single clock changes exactly one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| adv_ni | input | 1 | Address strobe, active low |
| oe_ni | input | 1 | Output enable from host, active low |
| we_ni | input | 1 | Write enable, active low |
| lane_i | input | 16 | Shared address/data lane, as seen at the pad |
| lane_o | output | 16 | Read data driven toward the lane |
| lane_oe_o | output | 1 | Enable for lane_o at the pad, active high |

## Verification
The scoreboard records, for each expected read word, the exact clock in which it must appear. A target that is one clock early or late on the first word is caught by that clock tag. A target that returns 15 or 17 words leaves the queue non-empty, or drives the lane when no word is expected. Three cases cover the register file index: a write burst that starts at entry 58 and wraps past 63, a read whose address differs only in its upper bits, and a single-beat write between known neighbours. An index that fails to wrap, an index that decodes too many bits, or a write that runs on would each return wrong words. Both a read and a write are aborted midway, and then a clean access follows. A target that keeps driving the lane, keeps writing, or keeps stale burst state would produce unexpected lane activity or corrupted read-back.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/mbt_phase_ctrl.sv
module mbt_phase_ctrl
  import mbt_pkg::*;
#(
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned RD_LAT    = 17,
  parameter int unsigned BURST_LEN = 16,
  localparam int unsigned CNT_W    = $clog2(RD_LAT + BURST_LEN + 2),
  localparam int unsigned BEAT_W   = $clog2(BURST_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              adv_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [LANE_W-1:0] lane_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              rd_load_o,
  output logic              rd_act_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_START = CNT_W'(RD_LAT - 2);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [LANE_W-1:0]  addr_q;
  logic               rd_pend_q;
  logic               rd_act_q;
  logic [BEAT_W-1:0]  beat_q;

  logic sel, adv_hit, in_data, wr_beat, rd_start, rd_more, rd_load;

  assign sel      = ~cs_ni;
  assign adv_hit  = sel & ~adv_ni;
  assign in_data  = sel & adv_ni & (phase_q != PH_IDLE);
  assign wr_beat  = in_data & ~we_ni;
  // first load on the edge ending clock RD_LAT-1
  assign rd_start = in_data & rd_pend_q & ~rd_act_q & (beat_q == '0) & (cnt_q == CNT_START);
  assign rd_more  = sel & rd_act_q & (beat_q < BEAT_LAST);
  assign rd_load  = rd_start | rd_more;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      addr_q    <= '0;
      rd_pend_q <= 1'b0;
      rd_act_q  <= 1'b0;
      beat_q    <= '0;
    end else if (!sel) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      rd_pend_q <= 1'b0;
      rd_act_q  <= 1'b0;
      beat_q    <= '0;
    end else begin
      cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      if (adv_hit) begin
        phase_q   <= PH_ADDR;
        addr_q    <= lane_i;
        rd_pend_q <= 1'b0;
        rd_act_q  <= 1'b0;
        beat_q    <= '0;
      end else begin
        if (phase_q == PH_ADDR) phase_q <= PH_DATA;
        if (in_data && !oe_ni) rd_pend_q <= 1'b1;
        if (wr_beat || rd_load) addr_q <= addr_q + 1'b1;
        if (rd_load) beat_q <= beat_q + 1'b1;
        if (rd_start) rd_act_q <= 1'b1;
        else if (rd_act_q && beat_q == BEAT_LAST) rd_act_q <= 1'b0;
      end
    end
  end

  assign wr_en_o   = wr_beat;
  assign idx_o     = addr_q[IDX_W-1:0];
  assign rd_load_o = rd_load;
  assign rd_act_o  = rd_act_q;

  // R2
  addr_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_hit |=> addr_q == $past(lane_i));
  // R3
  wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_beat |=> addr_q == $past(addr_q) + 1'b1);
  // R4
  first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_act_q) |-> $past(cnt_q) == CNT_START);
  // R5
  beat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act_q |-> beat_q <= BEAT_LAST);
  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !rd_act_q && beat_q == '0);
endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

  // R3
  store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/mbt_lane_drv.sv
module mbt_lane_drv #(
  parameter int unsigned LANE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_load_i,
  input  logic              rd_act_i,
  input  logic              cs_ni,
  input  logic              oe_ni,
  input  logic [LANE_W-1:0] rdata_i,
  output logic [LANE_W-1:0] lane_o,
  output logic              lane_oe_o
);
  logic [LANE_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        out_q <= '0;
    else if (rd_load_i) out_q <= rdata_i;
  end

  assign lane_o    = out_q;
  assign lane_oe_o = rd_act_i & ~cs_ni & ~oe_ni;

  // R5
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_i |=> lane_o == $past(rdata_i));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_load_i |=> $stable(lane_o));
endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target #(
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned RD_LAT    = 17,
  parameter int unsigned BURST_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              adv_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [LANE_W-1:0] lane_i,
  output logic [LANE_W-1:0] lane_o,
  output logic              lane_oe_o
);
  logic             wr_en, rd_load, rd_act;
  logic [IDX_W-1:0] idx;
  logic [LANE_W-1:0] rdata;

  mbt_phase_ctrl #(
    .LANE_W(LANE_W), .IDX_W(IDX_W), .RD_LAT(RD_LAT), .BURST_LEN(BURST_LEN)
  ) u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .adv_ni, .oe_ni, .we_ni, .lane_i,
    .wr_en_o(wr_en), .idx_o(idx), .rd_load_o(rd_load), .rd_act_o(rd_act)
  );

  mbt_regfile #(.DATA_W(LANE_W), .IDX_W(IDX_W)) u_rf (
    .clk_i, .rst_ni, .we_i(wr_en), .idx_i(idx), .wdata_i(lane_i), .rdata_o(rdata)
  );

  mbt_lane_drv #(.LANE_W(LANE_W)) u_drv (
    .clk_i, .rst_ni, .rd_load_i(rd_load), .rd_act_i(rd_act), .cs_ni, .oe_ni,
    .rdata_i(rdata), .lane_o, .lane_oe_o
  );

  // R6
  lane_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_oe_o |-> u_ctrl.rd_act_q && !cs_ni);
endmodule

// File: tb/sim_mux_bus_target.sv
`timescale 1ns/1ps
module sim_mux_bus_target;
  localparam int BL = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, adv_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [15:0] lane_i = '0;
  logic [15:0] lane_o;
  logic        lane_oe_o;

  int n_chk = 0, n_fail = 0;
  int cur_clk = -1;
  string cur_tag = "R1";
  int exp_d[$];
  int exp_c[$];
  logic [15:0] model [64];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_target u0 (
    .clk_i(clk), .rst_ni, .cs_ni, .adv_ni, .oe_ni, .we_ni,
    .lane_i, .lane_o, .lane_oe_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic tick(input int k);
    @(negedge clk);
    cur_clk = k;
  endtask

  task automatic idle_gap();
    for (int i = 0; i < 9; i++) begin
      tick(-1);
      cs_ni = 1'b1; adv_ni = 1'b1; oe_ni = 1'b1; we_ni = 1'b1; lane_i = '0;
    end
  endtask

  // abort_at: clock in which chip select is raised (0 = none)
  task automatic rd_burst(input logic [15:0] a, input int abort_at);
    int words;
    words = (abort_at == 0) ? BL : abort_at - 16;
    for (int i = 0; i < words; i++) begin
      exp_d.push_back(int'(model[(int'(a) + i) % 64]));
      exp_c.push_back(16 + i);
    end
    tick(1); cs_ni = 1'b0; adv_ni = 1'b0; lane_i = a;
    tick(2);
    for (int k = 3; k <= 32; k++) begin
      tick(k);
      if (k == abort_at) begin
        cs_ni = 1'b1; oe_ni = 1'b1; adv_ni = 1'b1;
        break;
      end
      adv_ni = 1'b1; oe_ni = 1'b0; lane_i = '0;
    end
    idle_gap();
    check(exp_d.size() == 0, (abort_at == 0) ? "R5" : "R7",
          "words left unreturned", exp_d.size(), 0);
    exp_d.delete(); exp_c.delete();
  endtask

  task automatic wr_burst(input logic [15:0] a, input int n, input logic [15:0] base,
                          input int step, input int abort_at);
    tick(1); cs_ni = 1'b0; adv_ni = 1'b0; lane_i = a;
    tick(2);
    for (int i = 0; i < n; i++) begin
      tick(3 + i);
      if (3 + i == abort_at) begin
        cs_ni = 1'b1; we_ni = 1'b1; adv_ni = 1'b1;
        break;
      end
      adv_ni = 1'b1; we_ni = 1'b0;
      lane_i = base + 16'(i * step);
      model[(int'(a) + i) % 64] = lane_i;
    end
    idle_gap();
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (lane_oe_o) begin
        if (cs_ni || oe_ni)
          check(1'b0, "R6", "drive without cs/oe", 1, 0);
        if (exp_d.size() == 0) begin
          check(1'b0, "R6", "unexpected lane drive at clock", cur_clk, -1);
        end else begin
          int d, c;
          d = exp_d.pop_front();
          c = exp_c.pop_front();
          check(int'(lane_o) == d, cur_tag, "read word", lane_o, d);
          check(cur_clk == c, "R4", "word clock", cur_clk, c);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    fork
      begin
        repeat (3) @(negedge clk);
        #1;
        check(lane_oe_o == 1'b0, "R1", "lane_oe in reset", lane_oe_o, 0);
        rst_ni = 1'b1;
        idle_gap();
        check(lane_oe_o == 1'b0, "R1", "lane_oe after reset", lane_oe_o, 0);
        cur_tag = "R1"; rd_burst(16'h0000, 0);
        cur_tag = "R3"; wr_burst(16'h0010, BL, 16'hA500, 1, 0);
        rd_burst(16'h0010, 0);
        wr_burst(16'h003A, BL, 16'h3C00, 3, 0);
        rd_burst(16'h003A, 0);
        cur_tag = "R2"; rd_burst(16'h7F3A, 0);
        cur_tag = "R8"; wr_burst(16'h0017, 1, 16'h5A5A, 1, 0);
        rd_burst(16'h0010, 0);
        cur_tag = "R7"; rd_burst(16'h0010, 20);
        rd_burst(16'h0030, 0);
        wr_burst(16'h0020, BL, 16'h7700, 5, 7);
        rd_burst(16'h0020, 0);
        done = 1'b1;
      end
      begin
        repeat (200000) @(posedge clk);
      end
    join_any
    disable fork;
    if (!done) check(1'b0, "R5", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule